// File: doc/BRIEF.md
# TPM FIFO Register Window

This block is the device side of a TPM-style register window reached over a byte-wide memory-mapped bus. A host claims the single locality through an access byte. It then moves the device through a command/response handshake using status bits. Command bytes are pushed through a data port, and response bytes are pulled from the same port. A two-byte burst count, read one byte at a time from consecutive offsets, tells the host how many data-port accesses it may make before polling again.

No real command is executed. A small internal responder waits a fixed number of cycles after go and then presents a computed response. That response is a ten-byte header carrying the response length, followed by bytes that fold in the XOR of the accepted command bytes. This gives host firmware or a bus master something realistic to exercise. A build parameter also gives a "no device" variant, whose bus always reads 0xFF.

Top module: `tpmfifo_regwin`

## Requirements
- R1: After reset the access byte (offset 0x000) reads 0x81, meaning bit 7 valid and bit 0 establishment with no locality active. The status byte (offset 0x018) reads 0x80, meaning only bit 7 valid. The burst count bytes at 0x019 (low) and 0x01A (high) read 0.
- R2: Writing the access byte with bit 1 (request use) or bit 3 (seize) set makes bit 5 (active) read 1, so the access byte reads 0xA1. Writing bit 5 while active releases the locality, and the byte reads 0x81 again.
- R3: While no locality is active, writes to the status byte and to the data port (offset 0x024) have no effect.
- R4: Writing bit 6 (ready) of the status byte enters the ready state from any state, discarding the command and response. Status then reads 0xC0 and the burst count reads min(BURST_MAX, MAX_BUF), which is 0x0120 by default.
- R5: After the first command byte, status bit 3 (expect) reads 1 and status reads 0x88. It stays 1 until the number of accepted bytes reaches the limit, and then status reads 0x80. The limit is the big-endian length held in command bytes 2 to 5, raised to at least 6 and capped at MAX_BUF.
- R6: Command bytes written after expect has cleared are ignored and do not alter the response. While receiving, the burst count equals min(BURST_MAX, MAX_BUF minus bytes accepted) when expect is 1, and 0 when expect is 0.
- R7: Writing status bit 5 (go) once expect has cleared starts execution, during which status reads 0x80. After RESP_DELAY cycles, bit 4 (data available) rises and status reads 0x90. A go written while expect is 1 is ignored.
- R8: Data-port reads return response byte i in order. Byte 0 is 0x80, byte 1 is 0x01, bytes 2 to 5 are RESP_LEN big-endian, and bytes 6 to 9 are 0x00. Every byte i of 10 or more is (i mod 256) XOR the XOR of all accepted command bytes. The burst count equals min(BURST_MAX, bytes remaining). Data available clears after the last byte.
- R9: Writing status bit 1 (retry) while a response is presented rewinds the read position, so the next data-port read returns byte 0 again.
- R10: Unmapped offsets, including 0x008, 0x01B, 0x100 and 0xF00, read 0x00. A data-port read when no response is presented returns 0x00.
- R11: With DEV_PRESENT = 0, every read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bus accesses take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset presented this cycle (combinational) |

## Verification
Commands are sent with a small explicit length (12), with a length below the 6-byte header (which must still close at 6 bytes), with a length far above the buffer (which must cap at 1280), and with random lengths from 6 to 40. These cases separate a correct length decode from an off-by-one or a missing clamp. Random trailing bytes after the command closes show whether overflow bytes leak into the response checksum. Retry, a premature go and ready written mid-stream each probe one edge of the state machine. An absent-device instance shares the same bus traffic to confirm it never drives anything but 0xFF.

// File: rtl/tpmfifo_pkg.sv
package tpmfifo_pkg;
   localparam int unsigned ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFS_ACCESS = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_BC_LO  = 12'h019;
   localparam logic [ADDR_W-1:0] OFS_BC_HI  = 12'h01A;
   localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h024;

   // access byte bit positions
   localparam int unsigned AB_VALID  = 7;
   localparam int unsigned AB_ACTIVE = 5;
   localparam int unsigned AB_SEIZE  = 3;
   localparam int unsigned AB_REQ    = 1;
   localparam int unsigned AB_EST    = 0;

   // status byte bit positions
   localparam int unsigned SB_VALID  = 7;
   localparam int unsigned SB_READY  = 6;
   localparam int unsigned SB_GO     = 5;
   localparam int unsigned SB_AVAIL  = 4;
   localparam int unsigned SB_EXPECT = 3;
   localparam int unsigned SB_RETRY  = 1;

   localparam int unsigned HDR_BYTES = 6;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READY,
      PH_RECV,
      PH_EXEC,
      PH_DONE
   } phase_t;
endpackage

// File: rtl/tpmfifo_locality.sv
module tpmfifo_locality
   import tpmfifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       req_use,
   input  logic       seize,
   input  logic       release_it,
   output logic       active,
   output logic [7:0] acc_byte
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
      end else if (wr_en) begin
         if (release_it && active) begin
            active <= 1'b0;
         end else if (req_use || seize) begin
            active <= 1'b1;
         end
      end
   end

   always_comb begin
      acc_byte            = 8'h00;
      acc_byte[AB_VALID]  = 1'b1;
      acc_byte[AB_ACTIVE] = active;
      acc_byte[AB_EST]    = 1'b1;
   end

   // R2
   grant_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (req_use || seize) && !release_it) |=> active);

   // R2
   release_drops_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && release_it && active) |=> !active);
endmodule

// File: rtl/tpmfifo_cmd_sink.sv
module tpmfifo_cmd_sink
   import tpmfifo_pkg::*;
#(
   parameter int unsigned MAX_BUF = 1280,
   localparam int unsigned CNT_W  = $clog2(MAX_BUF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wdata,
   output logic             expect_more,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       xsum
);
   localparam logic [31:0] MAX32 = 32'(MAX_BUF);

   logic [31:0]      len_q;
   logic [CNT_W-1:0] limit;
   logic             accept;

   always_comb begin
      limit = (len_q > MAX32) ? CNT_W'(MAX_BUF) : CNT_W'(len_q);
      expect_more = (count < CNT_W'(MAX_BUF)) &&
                    ((count < CNT_W'(HDR_BYTES)) || (count < limit));
   end

   assign accept = wr_en && expect_more;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         len_q <= '0;
         xsum  <= 8'h00;
      end else if (accept) begin
         count <= count + 1'b1;
         xsum  <= xsum ^ wdata;
         if (count >= CNT_W'(2) && count < CNT_W'(HDR_BYTES)) begin
            len_q <= {len_q[23:0], wdata};
         end
      end
   end

   // R5
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(MAX_BUF));

   // R6
   overflow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !expect_more && !clr) |=> ($stable(count) && $stable(xsum)));
endmodule

// File: rtl/tpmfifo_rsp_src.sv
module tpmfifo_rsp_src
   import tpmfifo_pkg::*;
#(
   parameter int unsigned RESP_LEN   = 14,
   parameter int unsigned RESP_DELAY = 20,
   localparam int unsigned PTR_W     = $clog2(RESP_LEN + 1),
   localparam int unsigned DLY_W     = $clog2(RESP_DELAY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             rd_en,
   input  logic             retry,
   input  logic [7:0]       seed,
   output logic             busy,
   output logic             loaded,
   output logic [PTR_W-1:0] remain,
   output logic [7:0]       rbyte
);
   localparam logic [31:0] RL32 = 32'(RESP_LEN);

   logic [DLY_W-1:0] dly;
   logic [PTR_W-1:0] rptr;
   logic [31:0]      shf;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         busy   <= 1'b0;
         loaded <= 1'b0;
         dly    <= '0;
         rptr   <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         loaded <= 1'b0;
         dly    <= '0;
         rptr   <= '0;
      end else if (busy) begin
         if (dly == DLY_W'(RESP_DELAY - 1)) begin
            busy   <= 1'b0;
            loaded <= 1'b1;
         end else begin
            dly <= dly + 1'b1;
         end
      end else if (loaded) begin
         if (retry) begin
            rptr <= '0;
         end else if (rd_en && rptr < PTR_W'(RESP_LEN)) begin
            rptr <= rptr + 1'b1;
         end
      end
   end

   assign remain = PTR_W'(RESP_LEN) - rptr;

   always_comb begin
      shf   = RL32 >> (8 * (5 - int'(rptr)));
      rbyte = 8'h00;
      if (rptr >= PTR_W'(RESP_LEN)) begin
         rbyte = 8'h00;
      end else if (rptr == PTR_W'(0)) begin
         rbyte = 8'h80;
      end else if (rptr == PTR_W'(1)) begin
         rbyte = 8'h01;
      end else if (rptr <= PTR_W'(5)) begin
         rbyte = shf[7:0];
      end else if (rptr <= PTR_W'(9)) begin
         rbyte = 8'h00;
      end else begin
         rbyte = 8'(rptr) ^ seed;
      end
   end

   // R7
   loaded_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded) |-> $past(busy));

   // R8
   rptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= PTR_W'(RESP_LEN));

   // R9
   retry_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && retry && !clr && !start) |=> (rptr == '0));
endmodule

// File: rtl/tpmfifo_regwin.sv
module tpmfifo_regwin
   import tpmfifo_pkg::*;
#(
   parameter int unsigned MAX_BUF     = 1280,
   parameter int unsigned BURST_MAX   = 288,
   parameter int unsigned RESP_LEN    = 14,
   parameter int unsigned RESP_DELAY  = 20,
   parameter bit          DEV_PRESENT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic [11:0] bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata
);
   localparam int unsigned CNT_W = $clog2(MAX_BUF + 1);
   localparam int unsigned PTR_W = $clog2(RESP_LEN + 1);
   localparam logic [31:0] BMX   = 32'(BURST_MAX);

   if (MAX_BUF < HDR_BYTES) begin : g_bad_buf
      $error("MAX_BUF must hold at least the header");
   end
   if (RESP_LEN < 10 || RESP_LEN > MAX_BUF) begin : g_bad_rsp
      $error("RESP_LEN must be in 10..MAX_BUF");
   end
   if (RESP_DELAY < 1) begin : g_bad_dly
      $error("RESP_DELAY must be at least 1");
   end
   if (BURST_MAX < 1 || BURST_MAX > 65535) begin : g_bad_burst
      $error("BURST_MAX must fit in 16 bits and be non-zero");
   end

   phase_t           phase;
   logic             active;
   logic [7:0]       acc_byte;
   logic             hit_acc, hit_sts, hit_lo, hit_hi, hit_dat;
   logic             sts_wr, dat_wr, dat_rd;
   logic             ready_cmd, go_cmd, retry_cmd;
   logic             rx_expect, exp_bit, avail;
   logic [CNT_W-1:0] rx_cnt;
   logic [7:0]       rx_xsum;
   logic             rs_busy, rs_loaded;
   logic [PTR_W-1:0] rs_left;
   logic [7:0]       rs_byte;
   logic [7:0]       sts_byte, rd_mux;
   logic [15:0]      burst;

   function automatic logic [15:0] cap(input logic [31:0] v);
      return (v > BMX) ? BMX[15:0] : v[15:0];
   endfunction

   assign hit_acc = bus_addr == OFS_ACCESS;
   assign hit_sts = bus_addr == OFS_STATUS;
   assign hit_lo  = bus_addr == OFS_BC_LO;
   assign hit_hi  = bus_addr == OFS_BC_HI;
   assign hit_dat = bus_addr == OFS_DATA;

   assign sts_wr = bus_en && bus_we && hit_sts && active;
   assign dat_wr = bus_en && bus_we && hit_dat && active;
   assign dat_rd = bus_en && !bus_we && hit_dat && active;

   assign ready_cmd = sts_wr && bus_wdata[SB_READY];
   assign go_cmd    = sts_wr && !ready_cmd && bus_wdata[SB_GO] &&
                      phase == PH_RECV && !rx_expect;
   assign retry_cmd = sts_wr && !ready_cmd && bus_wdata[SB_RETRY] &&
                      phase == PH_DONE;

   tpmfifo_locality u_loc (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_en && bus_we && hit_acc),
      .req_use    (bus_wdata[AB_REQ]),
      .seize      (bus_wdata[AB_SEIZE]),
      .release_it (bus_wdata[AB_ACTIVE]),
      .active     (active),
      .acc_byte   (acc_byte)
   );

   tpmfifo_cmd_sink #(.MAX_BUF(MAX_BUF)) u_sink (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (ready_cmd),
      .wr_en       (dat_wr && (phase == PH_READY || phase == PH_RECV)),
      .wdata       (bus_wdata),
      .expect_more (rx_expect),
      .count       (rx_cnt),
      .xsum        (rx_xsum)
   );

   tpmfifo_rsp_src #(.RESP_LEN(RESP_LEN), .RESP_DELAY(RESP_DELAY)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ready_cmd),
      .start  (go_cmd),
      .rd_en  (dat_rd && phase == PH_DONE),
      .retry  (retry_cmd),
      .seed   (rx_xsum),
      .busy   (rs_busy),
      .loaded (rs_loaded),
      .remain (rs_left),
      .rbyte  (rs_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else if (ready_cmd) begin
         phase <= PH_READY;
      end else if (go_cmd) begin
         phase <= PH_EXEC;
      end else begin
         case (phase)
            PH_READY: if (dat_wr) phase <= PH_RECV;
            PH_EXEC:  if (rs_loaded && !rs_busy) phase <= PH_DONE;
            default:  phase <= phase;
         endcase
      end
   end

   assign exp_bit = phase == PH_RECV && rx_expect;
   assign avail   = phase == PH_DONE && rs_left != '0;

   always_comb begin
      sts_byte            = 8'h00;
      sts_byte[SB_VALID]  = 1'b1;
      sts_byte[SB_READY]  = phase == PH_READY;
      sts_byte[SB_AVAIL]  = avail;
      sts_byte[SB_EXPECT] = exp_bit;

      if (phase == PH_READY || exp_bit) begin
         burst = cap(32'(MAX_BUF) - 32'(rx_cnt));
      end else if (avail) begin
         burst = cap(32'(rs_left));
      end else begin
         burst = 16'h0000;
      end

      rd_mux = 8'h00;
      if (hit_acc)      rd_mux = acc_byte;
      else if (hit_sts) rd_mux = sts_byte;
      else if (hit_lo)  rd_mux = burst[7:0];
      else if (hit_hi)  rd_mux = burst[15:8];
      else if (hit_dat) rd_mux = (phase == PH_DONE) ? rs_byte : 8'h00;
   end

   if (DEV_PRESENT) begin : g_present
      assign bus_rdata = rd_mux;
   end else begin : g_absent
      assign bus_rdata = 8'hFF;
   end

   // R4
   ready_enters_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_cmd |=> (phase == PH_READY));

   // R7
   early_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && bus_wdata[SB_GO] && !bus_wdata[SB_READY] && exp_bit) |=> (phase == PH_RECV));

   // R3
   inactive_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && (hit_sts || hit_dat) && !active &&
       (phase == PH_IDLE || phase == PH_READY || phase == PH_RECV)) |=> $stable(phase));

   // R6
   burst_zero_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RECV && !rx_expect) |-> (burst == 16'h0000));
endmodule

// File: tb/tpmfifo_regwin_tb_top.sv
module tpmfifo_regwin_tb_top;
   localparam int MAXB = 1280;
   localparam int BMAX = 288;
   localparam int RL   = 14;
   localparam int DLY  = 20;

   localparam logic [11:0] A_ACC = 12'h000;
   localparam logic [11:0] A_STS = 12'h018;
   localparam logic [11:0] A_BLO = 12'h019;
   localparam logic [11:0] A_BHI = 12'h01A;
   localparam logic [11:0] A_DAT = 12'h024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wd = '0;
   logic [7:0]  rdat, rdat_abs, last_abs;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          ended = 1'b0;

   always #10 clk = ~clk;

   tpmfifo_regwin #(.RESP_DELAY(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdat));

   tpmfifo_regwin #(.RESP_DELAY(DLY), .DEV_PRESENT(1'b0)) absent_i (
      .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdat_abs));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = a; wd = d;
      @(negedge clk);
      en = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b0; addr = a;
      #2;
      d = rdat;
      last_abs = rdat_abs;
      @(negedge clk);
      en = 1'b0;
   endtask

   function automatic int lim_of(input logic [31:0] lenf);
      if (lenf < 6) return 6;
      if (lenf > MAXB) return MAXB;
      return int'(lenf);
   endfunction

   function automatic logic [7:0] rsp_of(input int i, input logic [7:0] x);
      logic [31:0] rl;
      rl = 32'(RL);
      if (i == 0) return 8'h80;
      if (i == 1) return 8'h01;
      if (i <= 5) return 8'(rl >> (8 * (5 - i)));
      if (i <= 9) return 8'h00;
      return 8'(i) ^ x;
   endfunction

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic run_cmd(input logic [31:0] lenf, input int extra, input bit deep);
      logic [7:0] v, x, b;
      int lim, k;
      wr(A_STS, 8'h40);
      rd(A_STS, v); check("R4 status after ready", v, 8'hC0);
      rd(A_BLO, v); check("R4 burst low in ready", v, 8'h20);
      rd(A_BHI, v); check("R4 burst high in ready", v, 8'h01);
      lim = lim_of(lenf);
      x = 8'h00;
      for (int i = 0; i < lim + extra; i++) begin
         if (i >= 2 && i <= 5) b = 8'(lenf >> (8 * (5 - i)));
         else b = 8'($urandom);
         wr(A_DAT, b);
         if (i < lim) x ^= b;
         if (i == 0) begin
            rd(A_STS, v); check("R5 expect after first byte", v, 8'h88);
            if (deep) begin
               wr(A_STS, 8'h20);
               rd(A_STS, v); check("R7 go ignored while expecting", v, 8'h88);
            end
         end
         if (i == lim - 2) begin
            rd(A_STS, v); check("R5 expect before last byte", v, 8'h88);
            if (deep) begin
               rd(A_BLO, v);
               check("R6 burst tracks room", v, 8'(min_i(BMAX, MAXB - (lim - 1))));
            end
         end
         if (i == lim - 1) begin
            rd(A_STS, v); check("R5 expect cleared at limit", v, 8'h80);
            rd(A_BLO, v); check("R6 burst zero when closed", v, 8'h00);
         end
      end
      if (extra > 0) begin
         rd(A_STS, v); check("R6 status after overflow bytes", v, 8'h80);
      end
      wr(A_STS, 8'h20);
      rd(A_STS, v); check("R7 executing status", v, 8'h80);
      k = 0;
      do begin
         rd(A_STS, v);
         k++;
      end while (v != 8'h90 && k < 200);
      check("R7 data available", v, 8'h90);
      rd(A_BLO, v); check("R8 burst equals response length", v, 8'(RL));
      if (deep) begin
         for (int i = 0; i < 5; i++) begin
            rd(A_DAT, v); check("R8 response byte first pass", v, rsp_of(i, x));
         end
         wr(A_STS, 8'h02);
         rd(A_BLO, v); check("R9 burst restored after retry", v, 8'(RL));
      end
      for (int i = 0; i < RL; i++) begin
         rd(A_DAT, v);
         check(deep ? "R9 response byte after retry" : "R8 response byte", v, rsp_of(i, x));
      end
      rd(A_STS, v); check("R8 available cleared after last", v, 8'h80);
      rd(A_DAT, v); check("R10 data read past end", v, 8'h00);
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(A_ACC, v); check("R1 access reset", v, 8'h81);
      check("R11 absent access", last_abs, 8'hFF);
      rd(A_STS, v); check("R1 status reset", v, 8'h80);
      check("R11 absent status", last_abs, 8'hFF);
      rd(A_BLO, v); check("R1 burst low reset", v, 8'h00);
      rd(A_BHI, v); check("R1 burst high reset", v, 8'h00);
      check("R11 absent burst", last_abs, 8'hFF);

      wr(A_STS, 8'h40);
      rd(A_STS, v); check("R3 ready ignored when inactive", v, 8'h80);
      wr(A_DAT, 8'h11);
      rd(A_STS, v); check("R3 data write ignored when inactive", v, 8'h80);

      wr(A_ACC, 8'h02);
      rd(A_ACC, v); check("R2 request use grants", v, 8'hA1);
      wr(A_ACC, 8'h20);
      rd(A_ACC, v); check("R2 release", v, 8'h81);
      wr(A_ACC, 8'h08);
      rd(A_ACC, v); check("R2 seize grants", v, 8'hA1);

      rd(12'h008, v); check("R10 unmapped 0x008", v, 8'h00);
      rd(12'h01B, v); check("R10 unmapped 0x01B", v, 8'h00);
      rd(12'h100, v); check("R10 unmapped 0x100", v, 8'h00);
      rd(12'hF00, v); check("R10 unmapped 0xF00", v, 8'h00);
      check("R11 absent unmapped", last_abs, 8'hFF);
      rd(A_DAT, v); check("R10 data read idle", v, 8'h00);

      run_cmd(32'd12, 0, 1'b1);
      run_cmd(32'd2, 1, 1'b0);
      run_cmd(32'h0001_0000, 0, 1'b1);
      for (int t = 0; t < 6; t++) begin
         run_cmd(32'(6 + $urandom_range(34)), int'($urandom_range(2)), t[0]);
      end

      wr(A_STS, 8'h40);
      wr(A_DAT, 8'h01); wr(A_DAT, 8'h02); wr(A_DAT, 8'h03);
      wr(A_STS, 8'h40);
      rd(A_STS, v); check("R4 ready aborts reception", v, 8'hC0);
      rd(A_BHI, v); check("R4 burst high after abort", v, 8'h01);
      rd(A_DAT, v); check("R10 data read in ready", v, 8'h00);
      check("R11 absent data port", last_abs, 8'hFF);

      wr(A_ACC, 8'h20);
      wr(A_STS, 8'h20);
      rd(A_STS, v); check("R3 go ignored after release", v, 8'hC0);

      finish_up();
   end
endmodule